// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver

This block takes the clock and data wires of a PS/2 keyboard, which the keyboard drives, and turns each 11-bit frame into one scan code on a byte-wide output, marked by a strobe that lasts a single system clock. Both wires are brought into the system clock domain through flop synchronizers. The block takes one data sample on every falling edge of the synchronized keyboard clock.

A frame is accepted only if three fields are correct: the leading start bit, the odd-parity bit and the trailing stop bit. A frame whose stop bit is wrong is dropped without any sign. A frame whose parity is wrong is also dropped, and the block raises a one-cycle request so that a neighbouring transmitter sends the resend command byte (0xFE) to the keyboard. A watchdog counts system clocks while a frame is in progress. If the keyboard clock stays quiet longer than the configured time (100 us by default), the receiver abandons the partial frame and waits for a new start bit.

Top module: `kbd_frame_rx`

## Requirements
- R1: While reset is applied and right after it, `scan_valid_o` and `resend_req_o` are 0, and `resend_cmd_o` always reads 0xFE.
- R2: A frame is bit 0 = start (0), bits 1..8 = data least significant bit first, bit 9 = parity, bit 10 = stop (1). Each bit is the data level sampled at a falling keyboard-clock edge. A frame with all fields correct makes `scan_code_o` equal the data byte while `scan_valid_o` is high for exactly one system clock.
- R3: Parity is odd. The parity bit is 1 when the data byte holds an even number of ones and 0 otherwise. A frame with correct parity is accepted for every data value, including 0x00 and 0xFF.
- R4: A parity mismatch produces no `scan_valid_o` pulse. Instead `resend_req_o` is high for exactly one system clock, and the receiver returns to waiting for a start bit.
- R5: A stop bit sampled as 0 drops the frame: no `scan_valid_o` pulse and no `resend_req_o` pulse.
- R6: While the receiver waits for a start bit, a falling edge with the data line high is ignored. No output changes, and the next correct frame is received normally.
- R7: If no falling keyboard-clock edge arrives for `TIMEOUT_US` microseconds (computed from `CLK_KHZ`) while a frame is in progress, the receiver returns to waiting for a start bit. Each received bit restarts this interval, so gaps between bits that are shorter than the interval do not disturb a frame.
- R8: `scan_valid_o` and `resend_req_o` are never high in the same cycle.
- R9: After any frame ends, whether accepted, dropped or rejected for parity, the receiver is ready for the next frame, and that frame is decoded correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk_i | input | 1 | Keyboard clock wire, asynchronous |
| ps2_dat_i | input | 1 | Keyboard data wire, asynchronous |
| scan_code_o | output | 8 | Last received data byte |
| scan_valid_o | output | 1 | One-cycle strobe: `scan_code_o` holds a new code |
| resend_req_o | output | 1 | One-cycle request to transmit `resend_cmd_o` |
| resend_cmd_o | output | 8 | Byte to transmit on a resend request, fixed at 0xFE |

## Verification
When the step state or the bit counter is wrong inside the receiver, the frame goes out of step. Within that same frame, the port then shows a byte shifted by one or more bit positions, a missing strobe, or a resend request where the frame was in fact valid. These symptoms appear one or two system clocks after the stop-bit edge. A watchdog that fails to clear shows up only on the next frame: a frame sent after a long quiet spell then decodes as a shifted byte. A watchdog that clears too early corrupts a frame whose bits are spaced just under the limit. The bench drives both of these gaps.

// File: rtl/kfr_pkg.sv
package kfr_pkg;
    localparam int DATA_W = 8;
    localparam int BIT_CNT_W = $clog2(DATA_W);
    localparam logic [DATA_W-1:0] RESEND_CMD = 8'hFE;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_PAR  = 2'd2,
        ST_STOP = 2'd3
    } rx_step_e;

    typedef struct packed {
        rx_step_e              step;
        logic [DATA_W-1:0]     shreg;
        logic [BIT_CNT_W-1:0]  nbits;
        logic                  valid;
        logic                  resend;
    } rx_regs_t;
endpackage

// File: rtl/kfr_sync_edge.sv
module kfr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ck_raw_i,
    input  logic dt_raw_i,
    output logic fall_o,
    output logic dat_o
);
    typedef struct packed {
        logic [STAGES-1:0] ck;
        logic [STAGES-1:0] dt;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.ck   = {s_q.ck[STAGES-2:0], ck_raw_i};
        s_d.dt   = {s_q.dt[STAGES-2:0], dt_raw_i};
        s_d.prev = s_q.ck[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ck: '1, dt: '1, prev: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign fall_o = s_q.prev & ~s_q.ck[STAGES-1];
    assign dat_o  = s_q.dt[STAGES-1];

    // R2
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/kfr_idle_timer.sv
module kfr_idle_timer #(
    parameter int LIMIT = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic kick_i,
    output logic expire_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] count_d, count_q;

    always_comb begin
        if (!run_i || kick_i) begin
            count_d = '0;
        end else if (count_q == LAST) begin
            count_d = '0;
        end else begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign expire_o = run_i && !kick_i && (count_q == LAST);

    // R7
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q < CW'(LIMIT));
endmodule

// File: rtl/kfr_frame_fsm.sv
module kfr_frame_fsm
    import kfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              dat_i,
    input  logic              timeout_i,
    output logic [DATA_W-1:0] code_o,
    output logic              valid_o,
    output logic              resend_o,
    output logic              busy_o
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(DATA_W - 1);

    rx_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.valid  = 1'b0;
        r_d.resend = 1'b0;
        if (fall_i) begin
            unique case (r_q.step)
                ST_IDLE: begin
                    if (!dat_i) begin
                        r_d.step  = ST_DATA;
                        r_d.nbits = '0;
                    end
                end
                ST_DATA: begin
                    r_d.shreg = {dat_i, r_q.shreg[DATA_W-1:1]};
                    r_d.nbits = r_q.nbits + 1'b1;
                    if (r_q.nbits == LAST_BIT) begin
                        r_d.step = ST_PAR;
                    end
                end
                ST_PAR: begin
                    if (^{r_q.shreg, dat_i}) begin
                        r_d.step = ST_STOP;
                    end else begin
                        r_d.step   = ST_IDLE;
                        r_d.resend = 1'b1;
                    end
                end
                ST_STOP: begin
                    r_d.step  = ST_IDLE;
                    r_d.valid = dat_i;
                end
                default: r_d.step = ST_IDLE;
            endcase
        end else if (timeout_i) begin
            r_d.step = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{step: ST_IDLE, shreg: '0, nbits: '0, valid: 1'b0, resend: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign code_o   = r_q.shreg;
    assign valid_o  = r_q.valid;
    assign resend_o = r_q.resend;
    assign busy_o   = (r_q.step != ST_IDLE);

    // R8
    out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({r_q.valid, r_q.resend}));

    // R4
    resend_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.resend |=> !r_q.resend);

    // R4
    resend_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.resend |-> (r_q.step == ST_IDLE));

    // R5
    stop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i && r_q.step == ST_STOP && !dat_i) |=> (!r_q.valid && !r_q.resend));

    // R6
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i && r_q.step == ST_IDLE && dat_i) |=> (r_q.step == ST_IDLE && $stable(r_q.shreg)));

    // R7
    timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_i && !fall_i) |=> (r_q.step == ST_IDLE));
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx #(
    parameter int CLK_KHZ     = 50000,
    parameter int TIMEOUT_US  = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    output logic [7:0] scan_code_o,
    output logic       scan_valid_o,
    output logic       resend_req_o,
    output logic [7:0] resend_cmd_o
);
    localparam int TO_CYCLES = (CLK_KHZ * TIMEOUT_US) / 1000;

    logic fall, dat, busy, expire;

    kfr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ck_raw_i (ps2_clk_i),
        .dt_raw_i (ps2_dat_i),
        .fall_o   (fall),
        .dat_o    (dat)
    );

    kfr_idle_timer #(.LIMIT(TO_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (busy),
        .kick_i   (fall),
        .expire_o (expire)
    );

    kfr_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_i    (fall),
        .dat_i     (dat),
        .timeout_i (expire),
        .code_o    (scan_code_o),
        .valid_o   (scan_valid_o),
        .resend_o  (resend_req_o),
        .busy_o    (busy)
    );

    assign resend_cmd_o = kfr_pkg::RESEND_CMD;
endmodule

// File: tb/sim_kbd_frame_rx.sv
module sim_kbd_frame_rx;
    localparam int CLK_KHZ = 250000;
    localparam int TO_US   = 1;
    localparam int TO_CYC  = CLK_KHZ * TO_US / 1000;
    localparam int HALF    = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ps2_clk = 1'b1;
    logic       ps2_dat = 1'b1;
    logic [7:0] code;
    logic       valid, resend;
    logic [7:0] rcmd;

    always #2 clk = ~clk;

    kbd_frame_rx #(.CLK_KHZ(CLK_KHZ), .TIMEOUT_US(TO_US), .SYNC_STAGES(2)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .ps2_clk_i    (ps2_clk),
        .ps2_dat_i    (ps2_dat),
        .scan_code_o  (code),
        .scan_valid_o (valid),
        .resend_req_o (resend),
        .resend_cmd_o (rcmd)
    );

    int tests = 0;
    int fails = 0;
    int n_valid = 0;
    int n_resend = 0;
    int n_both = 0;
    logic [7:0] last_code = 8'h00;
    bit done = 1'b0;

    always @(negedge clk) begin
        if (valid) begin
            n_valid++;
            last_code = code;
        end
        if (resend) n_resend++;
        if (valid && resend) n_both++;
    end

    // {data, parity flip, stop bit, kind: 0 accept, 1 resend, 2 drop}
    localparam int NV = 9;
    localparam logic [11:0] VEC [NV] = '{
        {8'h1C, 1'b0, 1'b1, 2'd0},
        {8'hF0, 1'b0, 1'b1, 2'd0},
        {8'h00, 1'b0, 1'b1, 2'd0},
        {8'hFF, 1'b0, 1'b1, 2'd0},
        {8'hA5, 1'b1, 1'b1, 2'd1},
        {8'h5A, 1'b0, 1'b0, 2'd2},
        {8'h80, 1'b0, 1'b1, 2'd0},
        {8'h01, 1'b1, 1'b1, 2'd1},
        {8'h7E, 1'b0, 1'b1, 2'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input int gap);
        @(negedge clk);
        ps2_dat = b;
        repeat (HALF + gap) @(negedge clk);
        ps2_clk = 1'b0;
        repeat (HALF) @(negedge clk);
        ps2_clk = 1'b1;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic flip,
                              input logic stop, input int gap);
        send_bit(1'b0, gap);
        for (int i = 0; i < 8; i++) send_bit(d[i], gap);
        send_bit((~^d) ^ flip, gap);
        send_bit(stop, gap);
        repeat (30) @(negedge clk);
    endtask

    task automatic report;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            report();
            $finish;
        end
    end

    initial begin
        int v0, r0;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1 valid in reset", valid, 0);
        chk("R1 resend in reset", resend, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 valid after reset", valid, 0);
        chk("R1 resend cmd", rcmd, 8'hFE);

        // R2 R3 R4 R5 R9: table of frames back to back
        for (int k = 0; k < NV; k++) begin
            logic [7:0] d;
            logic [1:0] kind;
            d = VEC[k][11:4];
            kind = VEC[k][1:0];
            v0 = n_valid;
            r0 = n_resend;
            send_frame(d, VEC[k][3], VEC[k][2], 0);
            if (kind == 2'd0) begin
                chk("R2 one valid cycle", n_valid - v0, 1);
                chk("R3 code value", last_code, d);
                chk("R9 no resend on good frame", n_resend - r0, 0);
            end else if (kind == 2'd1) begin
                chk("R4 no valid on parity error", n_valid - v0, 0);
                chk("R4 one resend cycle", n_resend - r0, 1);
            end else begin
                chk("R5 no valid on bad stop", n_valid - v0, 0);
                chk("R5 no resend on bad stop", n_resend - r0, 0);
            end
        end

        // R6: idle edges with data high ignored
        v0 = n_valid;
        r0 = n_resend;
        for (int i = 0; i < 3; i++) send_bit(1'b1, 0);
        repeat (30) @(negedge clk);
        chk("R6 no output from idle high edges", (n_valid - v0) + (n_resend - r0), 0);
        send_frame(8'h29, 1'b0, 1'b1, 0);
        chk("R6 frame after idle edges", n_valid - v0, 1);
        chk("R6 code after idle edges", last_code, 8'h29);

        // R7: partial frame abandoned after quiet period
        send_bit(1'b0, 0);
        for (int i = 0; i < 3; i++) send_bit(1'b1, 0);
        repeat (TO_CYC + 100) @(negedge clk);
        v0 = n_valid;
        r0 = n_resend;
        send_frame(8'h3C, 1'b0, 1'b1, 0);
        chk("R7 frame after timeout", n_valid - v0, 1);
        chk("R7 code after timeout", last_code, 8'h3C);
        chk("R7 no resend after timeout", n_resend - r0, 0);

        // R7: gaps below the limit keep the frame alive
        v0 = n_valid;
        send_frame(8'hB4, 1'b0, 1'b1, TO_CYC - 2 * HALF - 30);
        chk("R7 slow frame accepted", n_valid - v0, 1);
        chk("R7 slow frame code", last_code, 8'hB4);

        // R8: never both outputs at once
        chk("R8 exclusive outputs", n_both, 0);

        done = 1'b1;
        report();
        $finish;
    end
endmodule